// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block supervises software by counting down from a programmed reload value. If software fails to service it, the first expiry raises an interrupt. If that interrupt has still not been cleared when the count expires again, the block raises a system reset request, provided reset generation is enabled. Counting advances only on cycles where an external tick enable is high. Counting can also be frozen while a debugger holds the processor halted, when that option is selected.

Software reaches the block through a simple synchronous register port. A write happens on the clock edge where `wrEn` is high. Reads are combinational from `addr`. The word addresses are: 0 reload value, 1 current count, 2 control, 3 interrupt clear, 4 raw status, 5 masked status, 6 lock. The control word uses these bits: bit 0 run, bit 1 interrupt mask (1 passes the interrupt out), bit 2 reset generation, bit 3 stall while halted. Raw and masked status are returned in bit 0. A lock register protects the configuration against runaway code.

Top module: `wdog_top`

## Requirements
- R1: After the synchronous reset, the reload value and the count read 32'hFFFF_FFFF. Control, raw status and lock read 0, and `irq` and `sysRst` are low.
- R2: A write to the reload register (address 0) loads the count with the written value on the same edge.
- R3: While run (control bit 0) is set, the count drops by one only on edges where `tickEn` is high. On other edges it holds.
- R4: When stall (control bit 3) is set and `dbgHalt` is high, the count holds. When stall is clear, `dbgHalt` has no effect.
- R5: An expiry is an active edge at which the count is 0. The expiry reloads the count from the reload value and sets raw status, so the period is reload+1 active edges.
- R6: `irq` and masked status equal raw status AND control bit 1. Raw status is unaffected by the mask.
- R7: Any write to address 3 clears raw status and reloads the count.
- R8: With reset generation (control bit 2) clear, a second expiry while raw status is set leaves `sysRst` low.
- R9: A clear written on the same edge as an active edge with the count at 0 takes priority. The count reloads, raw status ends at 0, and no reset is raised.
- R10: Writing any value other than 32'h1ACC_E551 to address 6 locks the block, and the lock register then reads 1. While locked, writes to the reload, control and clear addresses are ignored.
- R11: Writing 32'h1ACC_E551 to address 6 unlocks the block, and the lock register then reads 0.
- R12: With reset generation set, an expiry while raw status is already set drives `sysRst` high.
- R13: Once high, `sysRst` stays high, even through clears, until the synchronous reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tickEn | input | 1 | Count enable; the count moves only when high |
| dbgHalt | input | 1 | Debugger halt indication |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register word address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr` |
| irq | output | 1 | Masked timeout interrupt |
| sysRst | output | 1 | Sticky system reset request |

## Verification
Two functions can land on the same edge: the clear write and the expiry that would otherwise raise the reset. The bench arms reset generation and lets the first expiry set raw status. It then runs the count down to 0 and, in a single cycle, drives `tickEn` high together with a write to the clear address. The outcome is judged at the ports: `sysRst` must stay low, raw status must read 0 and the count must read the reload value.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int ADDR_W = 3;
  localparam logic [31:0] UNLOCK_KEY = 32'h1ACC_E551;

  localparam logic [ADDR_W-1:0] A_RELOAD = 3'd0;
  localparam logic [ADDR_W-1:0] A_COUNT  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd2;
  localparam logic [ADDR_W-1:0] A_CLEAR  = 3'd3;
  localparam logic [ADDR_W-1:0] A_RAW    = 3'd4;
  localparam logic [ADDR_W-1:0] A_MASKED = 3'd5;
  localparam logic [ADDR_W-1:0] A_LOCK   = 3'd6;

  localparam int CTRL_W   = 4;
  localparam int B_RUN    = 0;
  localparam int B_IRQEN  = 1;
  localparam int B_RSTEN  = 2;
  localparam int B_STALL  = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic loadWr;     // software wrote the reload register
    logic clrReload;  // interrupt clear reloads the count
    logic expReload;  // expiry reloads the count
    logic dec;        // decrement this edge
  } dpCmd_t;
endpackage

// File: rtl/wdog_dp.sv
module wdog_dp
  import wdog_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] RELOAD_INIT = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  dpCmd_t            cmd,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] loadVal,
  output logic [DATA_W-1:0] cntVal,
  output logic              cntZero
);
  logic [DATA_W-1:0] loadReg;
  logic [DATA_W-1:0] count;

  always_ff @(posedge clk) begin
    if (rst) begin
      loadReg <= RELOAD_INIT;
    end else if (cmd.loadWr) begin
      loadReg <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= RELOAD_INIT;
    end else if (cmd.loadWr) begin
      count <= wrData;
    end else if (cmd.clrReload || cmd.expReload) begin
      count <= loadReg;
    end else if (cmd.dec) begin
      count <= count - DATA_W'(1);
    end
  end

  assign loadVal = loadReg;
  assign cntVal  = count;
  assign cntZero = (count == '0);

  // R5
  exp_reload_chk: assert property (@(posedge clk) disable iff (rst)
    cmd.expReload |=> (count == $past(loadReg)));

  // R3
  dec_step_chk: assert property (@(posedge clk) disable iff (rst)
    cmd.dec |=> (count == $past(count) - DATA_W'(1)));
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tickEn,
  input  logic              dbgHalt,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] loadVal,
  input  logic [DATA_W-1:0] cntVal,
  input  logic              cntZero,
  output dpCmd_t            cmd,
  output logic [DATA_W-1:0] rdData,
  output logic              irq,
  output logic              sysRst
);
  logic [CTRL_W-1:0] ctrlReg;
  logic locked;
  logic rawStat;
  logic rstReq;
  logic active, cfgWr, loadWr, clrWr, expire;

  assign active = tickEn && ctrlReg[B_RUN] && !(ctrlReg[B_STALL] && dbgHalt);
  assign cfgWr  = wrEn && !locked;
  assign loadWr = cfgWr && (addr == A_RELOAD);
  assign clrWr  = cfgWr && (addr == A_CLEAR);
  assign expire = active && cntZero && !loadWr && !clrWr;

  always_comb begin
    cmd           = '0;
    cmd.loadWr    = loadWr;
    cmd.clrReload = clrWr && !loadWr;
    cmd.expReload = expire;
    cmd.dec       = active && !cntZero && !loadWr && !clrWr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrlReg <= '0;
    end else if (cfgWr && (addr == A_CTRL)) begin
      ctrlReg <= wrData[CTRL_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      locked <= 1'b0;
    end else if (wrEn && (addr == A_LOCK)) begin
      locked <= (wrData != DATA_W'(UNLOCK_KEY));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rawStat <= 1'b0;
    end else if (clrWr) begin
      rawStat <= 1'b0;
    end else if (expire) begin
      rawStat <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rstReq <= 1'b0;
    end else if (expire && rawStat && ctrlReg[B_RSTEN]) begin
      rstReq <= 1'b1;
    end
  end

  assign irq    = rawStat && ctrlReg[B_IRQEN];
  assign sysRst = rstReq;

  always_comb begin
    rdData = '0;
    case (addr)
      A_RELOAD: rdData = loadVal;
      A_COUNT:  rdData = cntVal;
      A_CTRL:   rdData = DATA_W'(ctrlReg);
      A_RAW:    rdData = DATA_W'(rawStat);
      A_MASKED: rdData = DATA_W'(irq);
      A_LOCK:   rdData = DATA_W'(locked);
      default:  rdData = '0;
    endcase
  end

  // R13
  rst_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    sysRst |=> sysRst);

  // R12
  rst_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sysRst) |-> $past(rawStat && ctrlReg[B_RSTEN]));

  // R5
  raw_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rawStat) |-> $past(cntZero));

  // R10
  lock_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
    (locked && wrEn && (addr == A_CTRL)) |=> $stable(ctrlReg));
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tickEn,
  input  logic              dbgHalt,
  input  logic              wrEn,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq,
  output logic              sysRst
);
  dpCmd_t cmd;
  logic [DATA_W-1:0] loadVal;
  logic [DATA_W-1:0] cntVal;
  logic cntZero;

  wdog_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .tickEn(tickEn), .dbgHalt(dbgHalt),
    .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .loadVal(loadVal), .cntVal(cntVal), .cntZero(cntZero),
    .cmd(cmd), .rdData(rdData), .irq(irq), .sysRst(sysRst)
  );

  wdog_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .cmd(cmd), .wrData(wrData),
    .loadVal(loadVal), .cntVal(cntVal), .cntZero(cntZero)
  );
endmodule

// File: tb/wdog_top_tb.sv
module wdog_top_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tickEn = 1'b0;
  logic dbgHalt = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [31:0] wrData = 32'd0;
  logic [31:0] rdData;
  logic irq, sysRst;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wdog_top u_dut (
    .clk(clk), .rst(rst), .tickEn(tickEn), .dbgHalt(dbgHalt),
    .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .irq(irq), .sysRst(sysRst)
  );

  typedef struct {
    int kind;          // 0 rdData, 1 irq, 2 sysRst
    logic [31:0] exp;
    string tag;
  } item_t;

  item_t sbq[$];
  event sampleEv, doneEv;

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      @(sampleEv);
      while (sbq.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sbq.pop_front();
        case (it.kind)
          0: act = rdData;
          1: act = {31'd0, irq};
          default: act = {31'd0, sysRst};
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
      ->doneEv;
    end
  end

  task automatic push(input int kind, input logic [31:0] exp, input string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    sbq.push_back(it);
    #1;
    ->sampleEv;
    @(doneEv);
  endtask

  task automatic expReg(input logic [2:0] a, input logic [31:0] exp, input string tag);
    addr = a;
    push(0, exp, tag);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic run(input int n);
    @(negedge clk);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    expReg(3'd0, 32'hFFFF_FFFF, "R1 reload");
    expReg(3'd1, 32'hFFFF_FFFF, "R1 count");
    expReg(3'd2, 32'd0, "R1 ctrl");
    expReg(3'd4, 32'd0, "R1 raw");
    expReg(3'd6, 32'd0, "R1 lock");
    push(1, 32'd0, "R1 irq");
    push(2, 32'd0, "R1 sysRst");

    // R2 reload write sets the count at once
    wr(3'd0, 32'd5);
    expReg(3'd1, 32'd5, "R2 count after reload write");
    wr(3'd2, 32'hF);

    // R3 counting gated by tickEn
    run(3);
    expReg(3'd1, 32'd2, "R3 three ticks");
    repeat (4) @(negedge clk);
    expReg(3'd1, 32'd2, "R3 hold without tick");

    // R4 stall while halted, and no stall when disabled
    dbgHalt = 1'b1;
    run(2);
    expReg(3'd1, 32'd2, "R4 stalled");
    wr(3'd2, 32'h7);
    run(1);
    expReg(3'd1, 32'd1, "R4 halt ignored without stall");
    dbgHalt = 1'b0;
    wr(3'd2, 32'hF);
    run(1);
    expReg(3'd1, 32'd0, "R5 reached zero");
    expReg(3'd4, 32'd0, "R5 no status at zero");
    run(1);
    expReg(3'd1, 32'd5, "R5 reload on expiry");
    expReg(3'd4, 32'd1, "R5 raw set");
    push(1, 32'd1, "R6 irq unmasked");

    // R6 mask
    wr(3'd2, 32'hD);
    push(1, 32'd0, "R6 irq masked");
    expReg(3'd5, 32'd0, "R6 masked status");
    expReg(3'd4, 32'd1, "R6 raw kept");
    wr(3'd2, 32'hF);

    // R7 clear
    run(2);
    wr(3'd3, 32'd0);
    expReg(3'd4, 32'd0, "R7 raw cleared");
    expReg(3'd1, 32'd5, "R7 count reloaded");

    // R8 no reset when disabled
    wr(3'd2, 32'h3);
    run(6);
    expReg(3'd4, 32'd1, "R8 first expiry");
    run(6);
    push(2, 32'd0, "R8 second expiry without reset enable");
    wr(3'd3, 32'd0);

    // R9 clear and expiry on the same edge
    wr(3'd2, 32'h7);
    run(6);
    expReg(3'd4, 32'd1, "R9 armed");
    run(5);
    expReg(3'd1, 32'd0, "R9 at zero");
    @(negedge clk);
    tickEn = 1'b1; addr = 3'd3; wrEn = 1'b1;
    @(negedge clk);
    tickEn = 1'b0; wrEn = 1'b0;
    push(2, 32'd0, "R9 no reset on collision");
    expReg(3'd4, 32'd0, "R9 raw cleared");
    expReg(3'd1, 32'd5, "R9 count reloaded");

    // R10 lock
    wr(3'd6, 32'h1234);
    expReg(3'd6, 32'd1, "R10 locked");
    wr(3'd0, 32'd9);
    expReg(3'd0, 32'd5, "R10 reload write ignored");
    expReg(3'd1, 32'd5, "R10 count untouched");
    wr(3'd2, 32'd0);
    expReg(3'd2, 32'd7, "R10 ctrl write ignored");
    // R11 unlock
    wr(3'd6, 32'h1ACC_E551);
    expReg(3'd6, 32'd0, "R11 unlocked");

    // R12 reset on second expiry
    run(6);
    push(1, 32'd1, "R12 first expiry irq");
    push(2, 32'd0, "R12 no reset yet");
    run(6);
    push(2, 32'd1, "R12 reset raised");

    // R13 sticky
    wr(3'd3, 32'd0);
    run(10);
    push(2, 32'd1, "R13 reset held");
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    push(2, 32'd0, "R13 released by block reset");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule